// File: doc/BRIEF.md
# Video DRAM Power-Up Initialization Sequencer

This block sits in a memory controller. After power is applied, it brings a dual-port video DRAM into a known, usable state. While it runs it owns the DRAM strobe pins.

The sequence has four steps:

1. It holds every strobe inactive through a timed pause whose length is derived from the clock frequency.
2. It issues a train of row-strobe dummy cycles. A mode input selects plain RAS-only dummies or CAS-before-RAS dummies, so that the device's internal refresh counter is exercised.
3. It issues a train of serial-clock dummy pulses.
4. It closes with a mode-register reset cycle, which puts the device into non-persistent masking.

Only after that does `ready` rise to release normal traffic. A synchronous `restart` replays the whole sequence from the pause.

All phase widths are parameters in clock ticks. The pause is `CLK_MHZ * PAUSE_US` ticks. The transfer strobe stays high throughout. No read, write or transfer is ever issued by this block.

Top module: `vdram_init_seq`

## Requirements
- R1: While `rst_n` is low the outputs are: `ras_n`, `cas_n`, `we_n` and `trg_n` high; `dsf`, `sc` and `ready` low. The vector {ras_n,cas_n,we_n,dsf,trg_n,sc,ready} reads 1110100.
- R2: After reset, the idle levels of R1 hold for exactly P = CLK_MHZ*PAUSE_US cycles before any strobe moves.
- R3: With RAS-only mode latched, the block issues DUMMIES row cycles. Each is RAS_HI_TICKS idle, then 1 lead cycle with all strobes high, then RAS_LO_TICKS with `ras_n` low and `cas_n` high.
- R4: With CAS-before-RAS mode latched, `cas_n` is low in the lead cycle and in the row-low phase of each row cycle, so CAS falls one cycle before RAS. The mode input is sampled only on the last pause cycle; changes after that have no effect.
- R5: After the row cycles, DUMMIES serial-clock pulses follow. Each is SC_LO_TICKS with `sc` low, then SC_HI_TICKS with `sc` high. `ras_n` stays high throughout.
- R6: The closing reset cycle has three parts: 1 cycle with `cas_n` low while `ras_n` is high, then RAS_LO_TICKS with both low, then RAS_HI_TICKS idle. During all of it `we_n` is high and `dsf` is low.
- R7: `ready` rises in the first cycle after the closing idle phase.
- R8: Once `ready` is high it stays high, the strobes stay idle, and `trg_n` and `we_n` stay high while `dsf` stays low.
- R9: A `restart` pulse sampled at a clock edge returns the outputs to the R1 levels at that edge, drops `ready`, and replays the full sequence from R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock, CLK_MHZ MHz |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart | input | 1 | Synchronous sequence restart |
| cbr_mode | input | 1 | 1 selects CAS-before-RAS dummies (sampled at pause end) |
| ras_n | output | 1 | Row address strobe, active low |
| cas_n | output | 1 | Column address strobe, active low |
| we_n | output | 1 | Write enable, held high |
| dsf | output | 1 | Special function select, held low |
| trg_n | output | 1 | Transfer/output-enable strobe, held high |
| sc | output | 1 | Serial port clock |
| ready | output | 1 | Initialization complete; gates normal traffic |

## Verification
The hardest situation to reach is a mode change that lands after the pause has ended, because the mode input then has to be ignored. A second hard case is a restart that arrives in the middle of the row-cycle train, with the counters part-way through.

The stimulus reaches both in a controlled way. It waits a fixed number of checked cycles past the pause, then flips `cbr_mode` in one run and pulses `restart` in another. The reference queue is rebuilt with the mode that should have been latched, so any leak of the late mode value, or any stale repetition count, shows up as a mismatch on the cycle where it appears.

// File: rtl/vdi_pkg.sv
package vdi_pkg;

  typedef enum logic [3:0] {
    S_PAUSE, S_RPRE, S_RLEAD, S_RLOW, S_SLO, S_SHI,
    S_XLEAD, S_XLOW, S_XPRE, S_READY
  } vdi_state_e;

  function automatic int unsigned pause_cycles(input int unsigned mhz, input int unsigned us);
    return mhz * us;
  endfunction

  function automatic int unsigned max5(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d,
                                       input int unsigned e);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    if (e > m) m = e;
    return m;
  endfunction

  // Length in ticks of each phase of the sequence.
  function automatic int unsigned phase_len(input vdi_state_e s, input int unsigned p,
                                            input int unsigned rlo, input int unsigned rhi,
                                            input int unsigned slo, input int unsigned shi);
    case (s)
      S_PAUSE:         return p;
      S_RPRE, S_XPRE:  return rhi;
      S_RLOW, S_XLOW:  return rlo;
      S_SLO:           return slo;
      S_SHI:           return shi;
      default:         return 1;
    endcase
  endfunction

  function automatic logic ras_active(input vdi_state_e s);
    return (s == S_RLOW) || (s == S_XLOW);
  endfunction

  function automatic logic cas_active(input vdi_state_e s, input logic cbr);
    return (s == S_XLEAD) || (s == S_XLOW) || (cbr && ((s == S_RLEAD) || (s == S_RLOW)));
  endfunction

endpackage

// File: rtl/vdi_timer.sv
module vdi_timer #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= RST_VAL;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/vdi_reps.sv
module vdi_reps #(
  parameter int unsigned W = 4,
  parameter logic [W-1:0] LAST = '0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic last
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (clr)  cnt <= '0;
    else if (inc)  cnt <= cnt + 1'b1;
  end

  assign last = (cnt == LAST);
endmodule

// File: rtl/vdram_init_seq.sv
module vdram_init_seq
  import vdi_pkg::*;
#(
  parameter int unsigned CLK_MHZ      = 100,
  parameter int unsigned PAUSE_US     = 200,
  parameter int unsigned RAS_LO_TICKS = 6,
  parameter int unsigned RAS_HI_TICKS = 6,
  parameter int unsigned SC_LO_TICKS  = 2,
  parameter int unsigned SC_HI_TICKS  = 2,
  parameter int unsigned DUMMIES      = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic cbr_mode,
  output logic ras_n,
  output logic cas_n,
  output logic we_n,
  output logic dsf,
  output logic trg_n,
  output logic sc,
  output logic ready
);
  localparam int unsigned PAUSE_TICKS = pause_cycles(CLK_MHZ, PAUSE_US);
  localparam int unsigned LONGEST = max5(PAUSE_TICKS, RAS_LO_TICKS, RAS_HI_TICKS,
                                         SC_LO_TICKS, SC_HI_TICKS);
  localparam int unsigned TW = $clog2(LONGEST + 1);
  localparam int unsigned RW = $clog2(DUMMIES + 1);

  vdi_state_e   st, nxt;
  logic         tmr_load, tmr_zero;
  logic [TW-1:0] load_val;
  logic         rep_clr, rep_inc, rep_last;
  logic         cbr_q;
  // Named event: last cycle of the pause (used by the checker).
  logic         pause_done;

  vdi_timer #(.W(TW), .RST_VAL(TW'(PAUSE_TICKS - 1))) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(load_val), .zero(tmr_zero)
  );

  vdi_reps #(.W(RW), .LAST(RW'(DUMMIES - 1))) u_reps (
    .clk(clk), .rst_n(rst_n), .clr(rep_clr), .inc(rep_inc), .last(rep_last)
  );

  assign pause_done = (st == S_PAUSE) && tmr_zero && !restart;

  always_comb begin
    nxt     = st;
    rep_clr = 1'b0;
    rep_inc = 1'b0;
    if (restart) begin
      nxt = S_PAUSE;
    end else if (tmr_zero) begin
      case (st)
        S_PAUSE: begin nxt = S_RPRE; rep_clr = 1'b1; end
        S_RPRE:  nxt = S_RLEAD;
        S_RLEAD: nxt = S_RLOW;
        S_RLOW:  begin
          if (rep_last) begin nxt = S_SLO; rep_clr = 1'b1; end
          else          begin nxt = S_RPRE; rep_inc = 1'b1; end
        end
        S_SLO:   nxt = S_SHI;
        S_SHI:   begin
          if (rep_last) nxt = S_XLEAD;
          else begin nxt = S_SLO; rep_inc = 1'b1; end
        end
        S_XLEAD: nxt = S_XLOW;
        S_XLOW:  nxt = S_XPRE;
        S_XPRE:  nxt = S_READY;
        default: nxt = S_READY;
      endcase
    end
  end

  assign tmr_load = restart || (tmr_zero && (st != S_READY));
  assign load_val = TW'(phase_len(nxt, PAUSE_TICKS, RAS_LO_TICKS, RAS_HI_TICKS,
                                   SC_LO_TICKS, SC_HI_TICKS) - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_PAUSE;
      cbr_q <= 1'b0;
    end else begin
      st <= nxt;
      if (pause_done) cbr_q <= cbr_mode;
    end
  end

  assign ras_n = !ras_active(st);
  assign cas_n = !cas_active(st, cbr_q);
  assign we_n  = 1'b1;
  assign dsf   = 1'b0;
  assign trg_n = 1'b1;
  assign sc    = (st == S_SHI);
  assign ready = (st == S_READY);
endmodule

// File: rtl/vdi_checker.sv
module vdi_checker #(
  parameter int unsigned P = 16,
  parameter int unsigned N = 8
) (
  input logic clk,
  input logic rst_n,
  input logic restart,
  input logic ras_n,
  input logic cas_n,
  input logic sc,
  input logic ready,
  input logic pause_done
);
  int unsigned since;
  int unsigned ras_falls;
  int unsigned sc_rises;
  logic        ras_q, sc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since <= 0; ras_falls <= 0; sc_rises <= 0; ras_q <= 1'b1; sc_q <= 1'b0;
    end else begin
      ras_q <= ras_n;
      sc_q  <= sc;
      if (restart) begin
        since <= 0; ras_falls <= 0; sc_rises <= 0;
      end else begin
        if (since < P) since <= since + 1;
        if (ras_q && !ras_n) ras_falls <= ras_falls + 1;
        if (!sc_q && sc)     sc_rises  <= sc_rises + 1;
      end
    end
  end

  p_pause_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pause_done |-> (since == P - 1));

  p_pause_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (since < P) |-> (ras_n && cas_n && !sc));

  p_cas_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && !cas_n) |-> $past(!cas_n));

  p_sc_ras_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!sc || ras_n));

  p_ready_counts_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> ((ras_falls == N + 1) && (sc_rises == N)));

  p_ready_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !restart) |=> ready);

  p_restart_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (ras_n && cas_n && !sc && !ready));
endmodule

bind vdram_init_seq vdi_checker #(.P(PAUSE_TICKS), .N(DUMMIES)) u_chk (
  .clk(clk), .rst_n(rst_n), .restart(restart), .ras_n(ras_n), .cas_n(cas_n),
  .sc(sc), .ready(ready), .pause_done(pause_done)
);

// File: tb/vdram_init_seq_test.sv
module vdram_init_seq_test;
  localparam int MHZ = 100, PUS = 1, RLO = 3, RHI = 2, SLO = 2, SHI = 2, NDUM = 8;
  localparam int P = MHZ * PUS;
  // {ras_n,cas_n,we_n,dsf,trg_n,sc,ready}
  localparam logic [6:0] IDLE = 7'b1110100;
  localparam logic [6:0] RDY  = 7'b1110101;

  logic clk = 1'b0, rst_n = 1'b0, restart = 1'b0, cbr = 1'b0;
  logic ras_n, cas_n, we_n, dsf, trg_n, sc, ready;
  int checks = 0, failures = 0;
  bit finished = 1'b0;
  logic [6:0] exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  vdram_init_seq #(.CLK_MHZ(MHZ), .PAUSE_US(PUS), .RAS_LO_TICKS(RLO), .RAS_HI_TICKS(RHI),
                   .SC_LO_TICKS(SLO), .SC_HI_TICKS(SHI), .DUMMIES(NDUM)) uut (
    .clk(clk), .rst_n(rst_n), .restart(restart), .cbr_mode(cbr),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .dsf(dsf), .trg_n(trg_n), .sc(sc), .ready(ready)
  );

  task automatic push(input logic [6:0] v, input string t, input int n);
    for (int i = 0; i < n; i++) begin exp_q.push_back(v); tag_q.push_back(t); end
  endtask

  // Reference waveform built from the requirements.
  task automatic build(input bit m, input string first);
    exp_q.delete(); tag_q.delete();
    push(IDLE, first, 1);
    push(IDLE, "R2", P - 1);
    for (int i = 0; i < NDUM; i++) begin
      push(IDLE, m ? "R4" : "R3", RHI);
      push(m ? 7'b1010100 : IDLE, m ? "R4" : "R3", 1);            // lead
      push(m ? 7'b0010100 : 7'b0110100, m ? "R4" : "R3", RLO);    // row low
    end
    for (int i = 0; i < NDUM; i++) begin
      push(IDLE, "R5", SLO);
      push(7'b1110110, "R5", SHI);
    end
    push(7'b1010100, "R6", 1);
    push(7'b0010100, "R6", RLO);
    push(IDLE, "R6", RHI);
    push(RDY, "R7", 1);
  endtask

  task automatic compare(input logic [6:0] e, input string t);
    logic [6:0] got;
    got = {ras_n, cas_n, we_n, dsf, trg_n, sc, ready};
    checks++;
    if (got !== e) begin
      failures++;
      $display("FAIL %s got=%b exp=%b t=%0t", t, got, e, $time);
    end
  endtask

  task automatic chk();
    if (exp_q.size() > 0) compare(exp_q.pop_front(), tag_q.pop_front());
    else compare(RDY, "R8");  // ready held, strobes idle
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); chk(); end
  endtask

  task automatic drain();
    while (exp_q.size() > 0) begin @(negedge clk); chk(); end
  endtask

  task automatic do_restart(input bit m);
    restart = 1'b1; cbr = m;
    build(m, "R9");
    @(negedge clk);
    restart = 1'b0;
    chk();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    compare(IDLE, "R1");                 // levels during reset
    rst_n = 1'b1;
    build(1'b0, "R1");
    chk();
    drain();                             // R2, R3, R5, R6, R7
    run(10);                             // R8
    do_restart(1'b1);                    // R9 from ready, CAS-before-RAS
    run(P + 2);
    cbr = 1'b0;                          // R4: late mode change ignored
    drain();
    run(5);
    do_restart(1'b0);                    // R9
    run(P + 20);
    do_restart(1'b1);                    // R9 mid row train
    drain();
    run(8);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule